// File: doc/BRIEF.md
# Single-Channel DMA Handshake Sequencer

This block moves data for one peripheral channel. When the peripheral raises its request, the sequencer asks the processor for the bus with a hold request. It waits for the hold acknowledge, and only accepts an acknowledge that arrives at least one cycle after the request went up. Once it owns the bus it runs single-word transfer cycles. Each word takes four clocks. In the first clock the address goes out, and the upper address byte is strobed into an external latch if that byte needs refreshing. In the middle clocks the acknowledge to the peripheral and the memory strobes are asserted. In the last clock the strobes are released and the word counter and address counter are updated.

A small write port, open only while the bus is not held, loads three things: the start address, the word count, and a mode word. The mode word sets the acknowledge polarity, the transfer type (memory read, memory write or memory-to-memory) and the address direction. A run ends in one of two ways. The word count can wrap below zero, and the block then pulses an open-drain style end-of-process drive for one cycle. Or an external active-low end-of-process line can be seen during the active cycles. Either way the request is dropped, and the channel stays quiet until the word count is written again.

Top module: `dma_hs_seq`

## Requirements
- R1: After reset, hold_req, aen, adstb and eop_drive_low are 0, mem_rd_n and mem_wr_n are 1, dack is 1, and addr_lo and addr_hi are 0.
- R2: A write with cfg_we high is decoded by cfg_sel: 0 loads the start address, 1 loads the word count, 2 loads the mode from cfg_wdata[3:0]. Writes made while hold_req is high are ignored.
- R3: A dreq seen while idle raises hold_req on the next cycle. A hold_ack present in that first hold_req cycle is ignored. With hold_ack held high, aen rises on the third cycle after dreq was sampled.
- R4: Each word occupies four cycles with aen high: an address cycle (C1), two strobe cycles (C2, C3) and an update cycle (C4). dack is active only in C2 and C3.
- R5: Mode bit 0 clear makes dack active-low, so its idle level is 1. Mode bit 0 set makes it active-high, so its idle level is 0.
- R6: Mode bits [2:1] select the transfer type. 00 (read) drives mem_rd_n low in C2 and C3. 01 (write) drives mem_wr_n low in C3 only. 10 (memory-to-memory) drives mem_rd_n low in C2 and mem_wr_n low in C3, and never activates dack. The two strobes are never low together.
- R7: While aen is high, addr_lo carries the low 8 address bits and addr_hi the upper 8 bits. After each word the address steps by +1, or by -1 when mode bit 3 is set.
- R8: adstb is high in C1 of the first word of a run, and in C1 of any later word whose upper address byte differs from the previous word's. It is low otherwise.
- R9: The word count drops by one per word. The word finished while the count was 0000h is the last one. In the cycle after its C4, hold_req is 0 and eop_drive_low is 1 for exactly one cycle.
- R10: If eop_in_n is held low for at least three cycles starting in C1, the current word completes and hold_req falls after its C4. eop_drive_low stays 0.
- R11: After either kind of termination, dreq is ignored until the word count is written again. After that write, a high dreq raises hold_req again.
- R12: If dreq is still high at C4 and the run has not ended, the next word's C1 follows at once with hold_req kept high. If dreq is low at C4, hold_req falls on the next cycle without terminating, so a later dreq starts a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select (0 address, 1 count, 2 mode) |
| cfg_wdata | input | 16 | Register write data |
| dreq | input | 1 | Peripheral transfer request, active high |
| hold_ack | input | 1 | Bus grant from the processor |
| eop_in_n | input | 1 | External end-of-process, active low, asynchronous |
| hold_req | output | 1 | Bus hold request to the processor |
| aen | output | 1 | Transfer address valid |
| adstb | output | 1 | Strobe for the external upper-address latch |
| addr_lo | output | 8 | Low address byte during transfers |
| addr_hi | output | 8 | Upper address byte on the shared data lines |
| dack | output | 1 | Peripheral acknowledge, programmable polarity |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| eop_drive_low | output | 1 | Pull-down enable for the open-drain end-of-process line |

## Verification
The hardest state to reach is the one where the upper-address-byte comparison must both skip and fire within a single run. The bench reaches it by loading a decrementing run just above a 256-byte boundary. The next word keeps the same upper byte and the word after that crosses it. An incrementing run that starts at a low byte of FFh checks the opposite direction. The external end-of-process is raised during the first address cycle, so its two-stage synchroniser delay must resolve before the update cycle of that same word. Write attempts made in the middle of a transfer are checked through the acknowledge polarity that would have flipped.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_C1,
        ST_C2,
        ST_C3,
        ST_C4
    } seq_st_e;

    typedef enum logic [1:0] {
        XF_READ  = 2'd0,
        XF_WRITE = 2'd1,
        XF_M2M   = 2'd2,
        XF_RSVD  = 2'd3
    } xfer_e;

    // bit 3: decrement, bits 2:1: transfer type, bit 0: acknowledge active high
    typedef struct packed {
        logic  dec;
        xfer_e xfer;
        logic  ack_hi;
    } mode_t;

    localparam logic [3:0] SEL_ADDR = 4'd0;
    localparam logic [3:0] SEL_CNT  = 4'd1;
    localparam logic [3:0] SEL_MODE = 4'd2;

endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_q, sh_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/dma_hs_cnt.sv
module dma_hs_cnt #(
    parameter int unsigned AW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned LO_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_addr,
    input  logic          ld_cnt,
    input  logic [AW-1:0] addr_val,
    input  logic [CW-1:0] cnt_val,
    input  logic          step,
    input  logic          dec,
    output logic [AW-1:0] addr_o,
    output logic          last_o,
    output logic          hi_chg_o
);

    localparam logic [AW-1:0] A_ONE = AW'(1);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t          ctr_q, ctr_d;
    logic [AW-1:0] nxt_addr;

    always_comb begin
        nxt_addr = dec ? (ctr_q.addr - A_ONE) : (ctr_q.addr + A_ONE);
        ctr_d    = ctr_q;
        if (step) begin
            ctr_d.addr = nxt_addr;
            ctr_d.cnt  = ctr_q.cnt - C_ONE;
        end
        if (ld_addr) ctr_d.addr = addr_val;
        if (ld_cnt)  ctr_d.cnt  = cnt_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign addr_o   = ctr_q.addr;
    assign last_o   = (ctr_q.cnt == '0);
    assign hi_chg_o = (nxt_addr[AW-1:LO_W] != ctr_q.addr[AW-1:LO_W]);

    // R9: a step taken at count zero leaves the counter at all ones
    a_r9_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_o && !ld_cnt) |=> (ctr_q.cnt == '1));

endmodule

// File: rtl/dma_hs_seq.sv
module dma_hs_seq
    import dma_hs_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned CW          = 16,
    parameter int unsigned LO_W        = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [3:0]         cfg_sel,
    input  logic [AW-1:0]      cfg_wdata,
    input  logic               dreq,
    input  logic               hold_ack,
    input  logic               eop_in_n,
    output logic               hold_req,
    output logic               aen,
    output logic               adstb,
    output logic [LO_W-1:0]    addr_lo,
    output logic [AW-LO_W-1:0] addr_hi,
    output logic               dack,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic               eop_drive_low
);

    localparam int unsigned HI_W = AW - LO_W;

    typedef struct packed {
        seq_st_e st;
        mode_t   mode;
        logic    hold_seen;
        logic    stb_need;
        logic    ext_seen;
        logic    done;
        logic    eop_pulse;
    } seq_t;

    seq_t          seq_q, seq_d;
    logic          eop_sync_n;
    logic          cfg_ok, ld_addr, ld_cnt, step;
    logic          active, ext_now;
    logic          last_w, hi_chg;
    logic [AW-1:0] cur_addr;
    logic          dack_act;

    dma_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_eop_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (eop_in_n),
        .q_o   (eop_sync_n)
    );

    dma_hs_cnt #(.AW(AW), .CW(CW), .LO_W(LO_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_addr  (ld_addr),
        .ld_cnt   (ld_cnt),
        .addr_val (cfg_wdata),
        .cnt_val  (cfg_wdata[CW-1:0]),
        .step     (step),
        .dec      (seq_q.mode.dec),
        .addr_o   (cur_addr),
        .last_o   (last_w),
        .hi_chg_o (hi_chg)
    );

    always_comb begin
        seq_d           = seq_q;
        seq_d.eop_pulse = 1'b0;
        step            = 1'b0;

        active  = (seq_q.st == ST_C1) || (seq_q.st == ST_C2) ||
                  (seq_q.st == ST_C3) || (seq_q.st == ST_C4);
        ext_now = seq_q.ext_seen || !eop_sync_n;

        cfg_ok  = cfg_we && (seq_q.st == ST_IDLE);
        ld_addr = cfg_ok && (cfg_sel == SEL_ADDR);
        ld_cnt  = cfg_ok && (cfg_sel == SEL_CNT);
        if (cfg_ok && (cfg_sel == SEL_MODE)) seq_d.mode = mode_t'(cfg_wdata[3:0]);
        if (ld_cnt) seq_d.done = 1'b0;

        if (active && !eop_sync_n) seq_d.ext_seen = 1'b1;

        case (seq_q.st)
            ST_IDLE: begin
                seq_d.hold_seen = 1'b0;
                seq_d.ext_seen  = 1'b0;
                seq_d.stb_need  = 1'b1;
                if (dreq && !seq_q.done) seq_d.st = ST_REQ;
            end
            ST_REQ: begin
                seq_d.hold_seen = 1'b1;
                if (seq_q.hold_seen && hold_ack) seq_d.st = ST_C1;
            end
            ST_C1: begin
                seq_d.stb_need = 1'b0;
                seq_d.st       = ST_C2;
            end
            ST_C2: seq_d.st = ST_C3;
            ST_C3: seq_d.st = ST_C4;
            ST_C4: begin
                step           = 1'b1;
                seq_d.stb_need = hi_chg;
                if (last_w || ext_now) begin
                    seq_d.st        = ST_IDLE;
                    seq_d.done      = 1'b1;
                    seq_d.eop_pulse = last_w;
                end else if (dreq) begin
                    seq_d.st = ST_C1;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.st       <= ST_IDLE;
            seq_q.stb_need <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        hold_req      = (seq_q.st != ST_IDLE);
        aen           = active;
        adstb         = (seq_q.st == ST_C1) && seq_q.stb_need;
        addr_lo       = active ? cur_addr[LO_W-1:0] : '0;
        addr_hi       = active ? cur_addr[AW-1:LO_W] : {HI_W{1'b0}};
        dack_act      = ((seq_q.st == ST_C2) || (seq_q.st == ST_C3)) &&
                        (seq_q.mode.xfer != XF_M2M);
        dack          = seq_q.mode.ack_hi ? dack_act : !dack_act;
        mem_rd_n      = !(((seq_q.mode.xfer == XF_READ) &&
                           ((seq_q.st == ST_C2) || (seq_q.st == ST_C3))) ||
                          ((seq_q.mode.xfer == XF_M2M) && (seq_q.st == ST_C2)));
        mem_wr_n      = !((seq_q.st == ST_C3) && (seq_q.mode.xfer != XF_READ));
        eop_drive_low = seq_q.eop_pulse;
    end

    // R3: grant in the first hold cycle never starts a transfer
    a_r3_first_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |=> !aen);
    // R2: mode cannot change while the bus is held
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req && $past(hold_req)) |-> $stable(seq_q.mode));
    // R4: acknowledge active only inside a transfer
    a_r4_dack_in_aen: assert property (@(posedge clk) disable iff (!rst_n)
        (dack == seq_q.mode.ack_hi) |-> aen);
    // R6: memory-to-memory never acknowledges
    a_r6_m2m_no_dack: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.mode.xfer == XF_M2M) |-> (dack != seq_q.mode.ack_hi));
    // R6: strobes are never low together
    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));
    // R8: address strobe is a single-cycle pulse within aen
    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |-> (aen && mem_rd_n && mem_wr_n));
    a_r8_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adstb |=> !adstb);
    // R9: end-of-process drive lasts one cycle, with the bus released
    a_r9_eop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        eop_drive_low |=> !eop_drive_low);
    a_r9_eop_released: assert property (@(posedge clk) disable iff (!rst_n)
        eop_drive_low |-> !hold_req);
    // R12: a word that ends the bus tenure was preceded by its C4 strobes released
    a_r12_aen_fall_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(aen) |-> (mem_rd_n && mem_wr_n && !hold_req));

endmodule

// File: tb/test_dma_hs_seq.sv
`timescale 1ns/1ps
module test_dma_hs_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        dreq, hold_ack, eop_in_n;
    logic        hold_req, aen, adstb, dack, mem_rd_n, mem_wr_n, eop_drive_low;
    logic [7:0]  addr_lo, addr_hi;

    int n_chk  = 0;
    int n_fail = 0;

    dma_hs_seq #(.AW(16), .CW(16), .LO_W(8), .SYNC_STAGES(2)) i_dma_hs_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .dreq          (dreq),
        .hold_ack      (hold_ack),
        .eop_in_n      (eop_in_n),
        .hold_req      (hold_req),
        .aen           (aen),
        .adstb         (adstb),
        .addr_lo       (addr_lo),
        .addr_hi       (addr_hi),
        .dack          (dack),
        .mem_rd_n      (mem_rd_n),
        .mem_wr_n      (mem_wr_n),
        .eop_drive_low (eop_drive_low)
    );

    always #2 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus(input string req, input logic e_aen, input logic e_stb,
                       input logic e_dack, input logic e_rd, input logic e_wr);
        chk(req, "aen", aen, e_aen);
        chk(req, "adstb", adstb, e_stb);
        chk(req, "dack", dack, e_dack);
        chk(req, "mem_rd_n", mem_rd_n, e_rd);
        chk(req, "mem_wr_n", mem_wr_n, e_wr);
    endtask

    task automatic cfg_write(input logic [3:0] sel, input logic [15:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic t_reset();
        chk("R1", "hold_req", hold_req, 0);
        bus("R1", 0, 0, 1, 1, 1);
        chk("R1", "eop_drive_low", eop_drive_low, 0);
        chk("R1", "addr", {addr_hi, addr_lo}, 16'h0000);
    endtask

    task automatic t_read_two_words();
        cfg_write(4'd0, 16'h12FF);
        cfg_write(4'd1, 16'h0001);
        cfg_write(4'd2, 16'h0000);
        hold_ack = 1'b1;
        dreq = 1'b1;
        tick();
        chk("R3", "hold_req rise", hold_req, 1);
        chk("R3", "aen in first hold cycle", aen, 0);
        tick();
        chk("R3", "aen after ignored ack", aen, 0);
        tick();
        bus("R4 R8 C1", 1, 1, 1, 1, 1);
        chk("R7", "addr first", {addr_hi, addr_lo}, 16'h12FF);
        tick();
        bus("R4 R6 C2", 1, 0, 0, 0, 1);
        cfg_we = 1'b1; cfg_sel = 4'd2; cfg_wdata = 16'h0001;
        tick();
        cfg_we = 1'b0;
        bus("R2 R6 C3", 1, 0, 0, 0, 1);
        tick();
        bus("R4 C4", 1, 0, 1, 1, 1);
        tick();
        bus("R12 R8 C1 next", 1, 1, 1, 1, 1);
        chk("R7", "addr incremented", {addr_hi, addr_lo}, 16'h1300);
        chk("R12", "hold kept", hold_req, 1);
        tick(); bus("R6 C2", 1, 0, 0, 0, 1);
        tick(); bus("R6 C3", 1, 0, 0, 0, 1);
        tick(); bus("R4 C4", 1, 0, 1, 1, 1);
        tick();
        chk("R9", "hold_req after last", hold_req, 0);
        chk("R9", "eop_drive_low pulse", eop_drive_low, 1);
        tick();
        chk("R9", "eop_drive_low single", eop_drive_low, 0);
        tick();
        chk("R11", "dreq ignored after tc", hold_req, 0);
        tick();
        chk("R11", "dreq still ignored", hold_req, 0);
        dreq = 1'b0;
        tick();
    endtask

    task automatic t_write_dec();
        cfg_write(4'd1, 16'h0005);
        cfg_write(4'd0, 16'h4001);
        cfg_write(4'd2, 16'h000B);
        chk("R5", "idle level active-high", dack, 0);
        dreq = 1'b1;
        tick(); tick();
        tick();
        bus("R8 C1 first", 1, 1, 0, 1, 1);
        chk("R7", "addr", {addr_hi, addr_lo}, 16'h4001);
        tick(); bus("R5 R6 C2", 1, 0, 1, 1, 1);
        tick(); bus("R5 R6 C3", 1, 0, 1, 1, 0);
        tick(); bus("R5 C4", 1, 0, 0, 1, 1);
        tick();
        bus("R8 C1 same hi", 1, 0, 0, 1, 1);
        chk("R7", "addr dec", {addr_hi, addr_lo}, 16'h4000);
        tick(); tick(); tick();
        tick();
        bus("R8 C1 hi change", 1, 1, 0, 1, 1);
        chk("R7", "addr dec cross", {addr_hi, addr_lo}, 16'h3FFF);
        tick();
        dreq = 1'b0;
        tick(); tick();
        tick();
        chk("R12", "hold drops on dreq low", hold_req, 0);
        chk("R12", "no eop pulse", eop_drive_low, 0);
        dreq = 1'b1;
        tick();
        chk("R12", "new run accepted", hold_req, 1);
        dreq = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        chk("R12", "idle after restart word", hold_req, 0);
    endtask

    task automatic t_m2m();
        cfg_write(4'd1, 16'h0000);
        cfg_write(4'd0, 16'h0050);
        cfg_write(4'd2, 16'h0004);
        dreq = 1'b1;
        tick(); tick();
        tick();
        bus("R6 m2m C1", 1, 1, 1, 1, 1);
        chk("R7", "addr", {addr_hi, addr_lo}, 16'h0050);
        tick(); bus("R6 m2m C2", 1, 0, 1, 0, 1);
        tick(); bus("R6 m2m C3", 1, 0, 1, 1, 0);
        tick(); bus("R6 m2m C4", 1, 0, 1, 1, 1);
        dreq = 1'b0;
        tick();
        chk("R9", "single word eop", eop_drive_low, 1);
        chk("R9", "hold_req low", hold_req, 0);
        tick();
    endtask

    task automatic t_ext_eop();
        cfg_write(4'd1, 16'h000A);
        cfg_write(4'd0, 16'h0200);
        cfg_write(4'd2, 16'h0000);
        dreq = 1'b1;
        tick(); tick();
        tick();
        bus("R10 C1", 1, 1, 1, 1, 1);
        eop_in_n = 1'b0;
        tick(); bus("R10 C2", 1, 0, 0, 0, 1);
        tick(); bus("R10 C3", 1, 0, 0, 0, 1);
        tick(); bus("R10 C4", 1, 0, 1, 1, 1);
        tick();
        eop_in_n = 1'b1;
        chk("R10", "hold_req after ext eop", hold_req, 0);
        chk("R10", "no eop drive", eop_drive_low, 0);
        tick();
        chk("R11", "dreq ignored after ext eop", hold_req, 0);
        tick();
        chk("R11", "still ignored", hold_req, 0);
        cfg_write(4'd1, 16'h0001);
        tick();
        chk("R11", "rewrite count rearms", hold_req, 1);
        dreq = 1'b0;
        for (int i = 0; i < 8; i++) tick();
        chk("R11", "idle again", hold_req, 0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        dreq = 1'b0; hold_ack = 1'b0; eop_in_n = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_read_two_words();
        t_write_dec();
        t_m2m();
        t_ext_eop();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

endmodule